// File: doc/BRIEF.md
# Nibble-Loaded Pattern Bank Register File

This block decodes CPU write cycles for one banking personality of a multi-mode cartridge mapper and holds the registers that personality needs: two program-bank bytes, one mirroring byte and eight pattern-table (CHR) bank bytes. A downstream translator reads these values from the output ports and turns them into memory addresses. That translator, and any interrupt logic, are outside this block.

Each CHR bank byte is built from two separate 4-bit writes. Address bit 0 picks the nibble, and a folded function of the upper address bits picks which of the eight bytes is written. An enable input is high while this personality is the active one. While it is low, every write is dropped. On the first enabled cycle after the enable was low, all CHR bytes are filled with ones. The program and mirroring bytes keep their values across a leave-and-return sequence.

Top module: `bankreg_file`

## Requirements
- R1: After reset, `prg0` is 0x00, `prg1` is 0x01, `mirror` is 0x00, and every CHR byte is 0xFF.
- R2: A write with address A in 0xB000..0xE003 inclusive targets CHR byte number ({A[13], A[12], A[11] | A[1]} + 2) mod 8. So 0xB000→0, 0xB002→1, 0xC000→2, 0xC002→3, 0xD000→4, 0xD002→5, 0xE000→6, 0xE002→7, and 0xB800→1.
- R3: In a CHR write, A[0]=0 loads data[3:0] into bits 3:0 of the target byte, and A[0]=1 loads data[3:0] into bits 7:4. The other nibble of that byte is kept, and data[7:4] is not used.
- R4: A write with A[15:12]=0x8 loads all 8 data bits into `prg0`. A write with A[15:12]=0xA loads all 8 data bits into `prg1`.
- R5: A write with A[15:12]=0x9 loads all 8 data bits into `mirror`.
- R6: Writes to any other address change no register. This covers addresses below 0x8000, 0xE004..0xEFFF and 0xF000..0xFFFF.
- R7: While `en` is low, no write changes any register.
- R8: In a cycle where `en` is high after being low (this includes the first enabled cycle after reset), every CHR byte becomes 0xFF and a CHR write in that cycle is discarded. A PRG or mirror write in that cycle still takes effect. PRG and mirror values are kept through the disabled period.
- R9: A write presented at a rising clock edge is visible on the outputs right after that edge. CHR byte i appears on `chr_banks[8i+7:8i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Personality active |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg0 | output | 8 | Program bank byte 0 |
| prg1 | output | 8 | Program bank byte 1 |
| mirror | output | 8 | Mirroring control byte |
| chr_banks | output | 64 | Eight CHR bank bytes, byte i at bits 8i+7:8i |

## Verification
Each register drives an output directly, so a write that lands in the wrong register shows on the ports one edge after the write. The same holds for a nibble that lands in the wrong half or a store that clobbers the kept half. The folded index mapping is the main risk, so every one of the sixteen nibble addresses is written with distinct data and the whole CHR vector is compared after each write. A missed or spurious refill on entry would leave stale or all-ones bytes that the very next comparison exposes.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

   localparam int ADDR_W = 16;
   localparam int IDX_W  = 3;

   localparam logic [3:0]        PAGE_PRG0 = 4'h8;
   localparam logic [3:0]        PAGE_MIR  = 4'h9;
   localparam logic [3:0]        PAGE_PRG1 = 4'hA;
   localparam logic [ADDR_W-1:0] CHR_FIRST = 16'hB000;
   localparam logic [ADDR_W-1:0] CHR_LAST  = 16'hE003;

   typedef struct packed {
      logic             chr_we;
      logic [IDX_W-1:0] chr_idx;
      logic             chr_hi;
      logic             prg0_we;
      logic             prg1_we;
      logic             mir_we;
   } wr_dec_t;

endpackage

// File: rtl/bankreg_decode.sv
module bankreg_decode
   import bankreg_pkg::*;
(
   input  logic              en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output wr_dec_t           dec
);

   logic             live;
   logic             in_chr;
   logic [IDX_W-1:0] folded;

   assign live   = en & wr_en;
   assign in_chr = (addr >= CHR_FIRST) && (addr <= CHR_LAST);
   // upper page bits folded with A1 into a 3-bit slot, then rotated by two
   assign folded = {addr[13], addr[12], addr[11] | addr[1]};

   always_comb begin
      dec         = '0;
      dec.chr_idx = folded + IDX_W'(2);
      dec.chr_hi  = addr[0];
      if (live) begin
         if (in_chr) begin
            dec.chr_we = 1'b1;
         end else begin
            dec.prg0_we = (addr[15:12] == PAGE_PRG0);
            dec.prg1_we = (addr[15:12] == PAGE_PRG1);
            dec.mir_we  = (addr[15:12] == PAGE_MIR);
         end
      end
   end

endmodule

// File: rtl/bankreg_nibreg.sv
module bankreg_nibreg #(
   parameter int NIB_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill,
   input  logic               we_lo,
   input  logic               we_hi,
   input  logic [NIB_W-1:0]   din,
   output logic [2*NIB_W-1:0] q
);

   logic [NIB_W-1:0] lo_q;
   logic [NIB_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '1;
         hi_q <= '1;
      end else if (fill) begin
         lo_q <= '1;
         hi_q <= '1;
      end else begin
         if (we_lo) lo_q <= din;
         if (we_hi) hi_q <= din;
      end
   end

   assign q = {hi_q, lo_q};

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
   import bankreg_pkg::*;
#(
   parameter int          DATA_W        = 8,
   parameter int          NIB_W         = 4,
   parameter int          NUM_CHR       = 8,
   parameter int          FILL_ON_ENTRY = 1,
   parameter logic [7:0]  PRG0_RST      = 8'h00,
   parameter logic [7:0]  PRG1_RST      = 8'h01
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en,
   input  logic                        wr_en,
   input  logic [15:0]                 wr_addr,
   input  logic [DATA_W-1:0]           wr_data,
   output logic [DATA_W-1:0]           prg0,
   output logic [DATA_W-1:0]           prg1,
   output logic [DATA_W-1:0]           mirror,
   output logic [NUM_CHR*DATA_W-1:0]   chr_banks
);

   localparam int CHR_BITS = NUM_CHR * DATA_W;

   initial begin
      if (DATA_W != 2 * NIB_W)
         $error("bankreg_file: DATA_W must hold exactly two nibbles");
      if (NUM_CHR != (1 << IDX_W))
         $error("bankreg_file: the folded index addresses exactly eight banks");
      if (DATA_W != 8)
         $error("bankreg_file: reset constants are byte wide");
      if (FILL_ON_ENTRY != 0 && FILL_ON_ENTRY != 1)
         $error("bankreg_file: FILL_ON_ENTRY is 0 or 1");
      if (CHR_BITS != 64)
         $error("bankreg_file: packed bank vector width mismatch");
   end

   wr_dec_t dec;
   logic    entry;

   bankreg_decode u_decode (
      .en    (en),
      .wr_en (wr_en),
      .addr  (wr_addr),
      .dec   (dec)
   );

   generate
      if (FILL_ON_ENTRY != 0) begin : g_entry
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= en;
         end
         assign entry = en & ~en_q;
      end else begin : g_no_entry
         assign entry = 1'b0;
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CHR; gi++) begin : g_chr
         logic hit;
         assign hit = dec.chr_we & (dec.chr_idx == IDX_W'(gi));
         bankreg_nibreg #(.NIB_W(NIB_W)) u_nib (
            .clk   (clk),
            .rst_n (rst_n),
            .fill  (entry),
            .we_lo (hit & ~dec.chr_hi),
            .we_hi (hit &  dec.chr_hi),
            .din   (wr_data[NIB_W-1:0]),
            .q     (chr_banks[gi*DATA_W +: DATA_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prg0   <= PRG0_RST;
         prg1   <= PRG1_RST;
         mirror <= '0;
      end else begin
         if (dec.prg0_we) prg0   <= wr_data;
         if (dec.prg1_we) prg1   <= wr_data;
         if (dec.mir_we)  mirror <= wr_data;
      end
   end

endmodule

// File: rtl/bankreg_chk.sv
module bankreg_chk #(
   parameter int DATA_W        = 8,
   parameter int NUM_CHR       = 8,
   parameter int FILL_ON_ENTRY = 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      en,
   input logic                      wr_en,
   input logic [15:0]               wr_addr,
   input logic [DATA_W-1:0]         wr_data,
   input logic [DATA_W-1:0]         prg0,
   input logic [DATA_W-1:0]         prg1,
   input logic [DATA_W-1:0]         mirror,
   input logic [NUM_CHR*DATA_W-1:0] chr_banks
);

   // R4
   prg0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wr_en && wr_addr[15:12] == 4'h8) |=> prg0 == $past(wr_data));

   // R4
   prg1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wr_en && wr_addr[15:12] == 4'hA) |=> prg1 == $past(wr_data));

   // R5
   mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wr_en && wr_addr[15:12] == 4'h9) |=> mirror == $past(wr_data));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(chr_banks) && $stable(prg0) && $stable(prg1) && $stable(mirror)));

   // R6
   top_page_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:12] == 4'hF) |=> ($stable(prg0) && $stable(prg1) && $stable(mirror)));

   generate
      if (FILL_ON_ENTRY != 0) begin : g_fill_chk
         // R8
         entry_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en) |=> chr_banks == '1);
      end
   endgenerate

endmodule

bind bankreg_file bankreg_chk #(
   .DATA_W        (DATA_W),
   .NUM_CHR       (NUM_CHR),
   .FILL_ON_ENTRY (FILL_ON_ENTRY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .prg0      (prg0),
   .prg1      (prg1),
   .mirror    (mirror),
   .chr_banks (chr_banks)
);

// File: tb/bankreg_file_bench.sv
module bankreg_file_bench;

   localparam time CLK_P = 8ns;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        en;
   logic        wr_en;
   logic [15:0] wr_addr;
   logic [7:0]  wr_data;
   logic [7:0]  prg0, prg1, mirror;
   logic [63:0] chr_banks;

   always #(CLK_P / 2) clk = ~clk;

   bankreg_file u_bankreg_file (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .prg0      (prg0),
      .prg1      (prg1),
      .mirror    (mirror),
      .chr_banks (chr_banks)
   );

   int   vectors = 0;
   int   miscompares = 0;
   bit   done = 1'b0;

   logic [7:0] m_chr [8];
   logic [7:0] m_prg0, m_prg1, m_mir;
   logic       m_en_q;

   function automatic logic [63:0] pack_model();
      logic [63:0] v;
      for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_chr[i];
      return v;
   endfunction

   // index rule from R2
   function automatic int slot_of(input logic [15:0] a);
      logic [2:0] f;
      f = {a[13], a[12], a[11] | a[1]};
      return int'(3'(f + 3'd2));
   endfunction

   task automatic check_all(input string req);
      vectors++;
      if (prg0 !== m_prg0 || prg1 !== m_prg1 || mirror !== m_mir || chr_banks !== pack_model()) begin
         miscompares++;
         $display("FAIL %s: got prg0=%h prg1=%h mir=%h chr=%h, expected prg0=%h prg1=%h mir=%h chr=%h",
                  req, prg0, prg1, mirror, chr_banks, m_prg0, m_prg1, m_mir, pack_model());
      end
   endtask

   // one clock cycle; called just after a falling edge
   task automatic step(input logic e, input logic w, input logic [15:0] a, input logic [7:0] d);
      logic entry;
      en = e; wr_en = w; wr_addr = a; wr_data = d;
      @(posedge clk);
      entry  = e && !m_en_q;
      m_en_q = e;
      if (e) begin
         if (entry) begin
            for (int i = 0; i < 8; i++) m_chr[i] = 8'hFF;
         end else if (w && a >= 16'hB000 && a <= 16'hE003) begin
            if (a[0]) m_chr[slot_of(a)][7:4] = d[3:0];
            else      m_chr[slot_of(a)][3:0] = d[3:0];
         end
         if (w && !(a >= 16'hB000 && a <= 16'hE003)) begin
            if (a[15:12] == 4'h8) m_prg0 = d;
            if (a[15:12] == 4'hA) m_prg1 = d;
            if (a[15:12] == 4'h9) m_mir  = d;
         end
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; en = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) m_chr[i] = 8'hFF;
      m_prg0 = 8'h00; m_prg1 = 8'h01; m_mir = 8'h00; m_en_q = 1'b0;
      check_all("R1 reset values");
      step(1'b1, 1'b0, 16'h0000, 8'h00);
      check_all("R1 first enabled cycle");
   endtask

   task automatic t_map();
      logic [15:0] bases [4] = '{16'hB000, 16'hC000, 16'hD000, 16'hE000};
      for (int p = 0; p < 4; p++) begin
         for (int s = 0; s < 4; s++) begin
            logic [15:0] a;
            a = bases[p] | 16'(s);
            step(1'b1, 1'b1, a, 8'(p * 4 + s + 8'h30));
            check_all("R2 index map");
         end
      end
      step(1'b1, 1'b1, 16'hB800, 8'h0C);
      check_all("R2 A11 folds into slot 1");
   endtask

   task automatic t_nibble();
      step(1'b1, 1'b1, 16'hC002, 8'hA5);
      check_all("R3 low nibble, R9 next edge");
      step(1'b1, 1'b1, 16'hC003, 8'h7E);
      check_all("R3 high nibble keeps low");
      step(1'b1, 1'b1, 16'hC002, 8'hF1);
      check_all("R3 upper data bits ignored");
   endtask

   task automatic t_prg();
      step(1'b1, 1'b1, 16'h8000, 8'h9C);
      check_all("R4 prg0 load");
      step(1'b1, 1'b1, 16'hAFFF, 8'h3B);
      check_all("R4 prg1 load");
      step(1'b1, 1'b1, 16'h8123, 8'hE4);
      check_all("R4 prg0 page decode");
   endtask

   task automatic t_mirror();
      step(1'b1, 1'b1, 16'h9000, 8'hC7);
      check_all("R5 mirror load");
      step(1'b1, 1'b1, 16'h9ABC, 8'h01);
      check_all("R5 mirror page decode");
   endtask

   task automatic t_ignored();
      step(1'b1, 1'b1, 16'h7FFF, 8'h55);
      check_all("R6 below 8000");
      step(1'b1, 1'b1, 16'hE004, 8'h66);
      check_all("R6 past CHR range");
      step(1'b1, 1'b1, 16'hF000, 8'h77);
      check_all("R6 top page");
   endtask

   task automatic t_disabled();
      step(1'b0, 1'b1, 16'hB000, 8'h00);
      check_all("R7 CHR write while off");
      step(1'b0, 1'b1, 16'h8000, 8'h11);
      check_all("R7 prg write while off");
      step(1'b0, 1'b1, 16'h9000, 8'h22);
      check_all("R7 mirror write while off");
   endtask

   task automatic t_entry();
      step(1'b1, 1'b1, 16'hD000, 8'h02);
      step(1'b0, 1'b0, 16'h0000, 8'h00);
      step(1'b1, 1'b1, 16'hB000, 8'h03);
      check_all("R8 refill, CHR write dropped");
      step(1'b0, 1'b0, 16'h0000, 8'h00);
      step(1'b1, 1'b1, 16'h9000, 8'h5A);
      check_all("R8 mirror write on entry cycle");
      step(1'b1, 1'b1, 16'hB000, 8'h03);
      check_all("R8 CHR write after entry");
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_map();
      t_nibble();
      t_prg();
      t_mirror();
      t_ignored();
      t_disabled();
      t_entry();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule